// File: doc/BRIEF.md
# Procedure Migration Table Coordinator

This block holds one bookkeeping record per processor of a sixteen-core cluster, used when a core hands a procedure off to a neighbour that runs in a better voltage and temperature condition. Each record stores the pointer to the shared argument stack, the entry address of the procedure's service routine and a two-bit lifecycle state. A core that wants to hand a procedure off posts its own record. That raises a pending service request at every other core. A core that is willing to serve issues a claim. The block searches the records in a circle, starting just after the claimer's own index, and atomically moves the first waiting record to running.

When the serving core reports completion, the record moves to done and the owning core gets a one-cycle acknowledge pulse. Each live record has its own timer. If a record stays waiting or running for the programmed number of cycles, a timeout flag is set. The OR of all these flags forms a cluster-wide request to lower the clock frequency. The owner returns its record to empty once it has read the results, or withdraws it after a timeout.

Every core drives a single command port: a valid bit, a 2-bit operation, an entry index, a stack pointer and an address. The matching response is registered and appears one cycle later.

Top module: `hop_table`

## Requirements
- R1: After reset every record is empty (state code 0). `req_irq`, `ack_irq`, `rsp_valid`, `tmo_flag` and `slow_req` are all low.
- R2: Each command gets exactly one response, with `rsp_valid` high in the next cycle. Response codes are OK=0, RETRY=1, ERR=2, NONE=3, and operation codes are POST=0, CLAIM=1, FINISH=2, CLEAR=3. A POST from core k on an empty record k stores the stack pointer and address, makes the record waiting (code 1) and answers OK. A POST on a non-empty record answers ERR and leaves the record unchanged.
- R3: An accepted POST from core k sets the pending request of every core except k. A core's pending request is cleared when that core issues a CLAIM, but a POST in the same cycle keeps it set. `req_irq[j]` is pending[j] AND `irq_en[j]` AND (NOT `idle_only[j]` OR `core_idle[j]`).
- R4: A CLAIM from core k that wins arbitration examines records k+1, k+2, ... modulo 16 and never its own record. It takes the first waiting record, sets it to running (code 2), and returns OK with the record index, stack pointer and address. If no record is waiting, it answers NONE.
- R5: When several CLAIMs arrive in the same cycle, only the lowest-numbered core is served. Every other claimer gets RETRY and no record changes on their behalf.
- R6: A FINISH from core k naming record e succeeds only if e is running and was claimed by core k. The record then becomes done (code 3), the answer is OK, and `ack_irq[e]` pulses for exactly one cycle, aligned with the response. Any other FINISH answers ERR and raises no acknowledge.
- R7: A CLEAR from core k empties record k when it is done or waiting, and answers OK. A CLEAR on an empty or running record answers ERR. If record k is claimed in the same cycle, the claim takes effect and the CLEAR answers ERR.
- R8: `tmo_flag[e]` rises exactly `tmo_limit` cycles after record e became waiting, provided the record stays waiting or running for that whole span. The flag holds until record e is cleared or posted again. A record that reaches done before the limit never raises the flag. `slow_req` is the OR of all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | NCORE | Command strobe per core |
| cmd_op | input | 2*NCORE | Operation code per core |
| cmd_idx | input | IDX_W*NCORE | Record index for FINISH |
| cmd_sp | input | SP_W*NCORE | Shared-stack pointer for POST |
| cmd_addr | input | AD_W*NCORE | Service routine address for POST |
| irq_en | input | NCORE | Request interrupt enable per core |
| idle_only | input | NCORE | Deliver request interrupt only while idle |
| core_idle | input | NCORE | Core reports idle |
| tmo_limit | input | TMR_W | Timeout length in cycles |
| rsp_valid | output | NCORE | Response strobe per core |
| rsp_code | output | 2*NCORE | Response code per core |
| rsp_idx | output | IDX_W*NCORE | Claimed record index |
| rsp_sp | output | SP_W*NCORE | Claimed record stack pointer |
| rsp_addr | output | AD_W*NCORE | Claimed record address |
| entry_state | output | 2*NCORE | Lifecycle state of each record |
| req_irq | output | NCORE | Service request interrupt per core |
| ack_irq | output | NCORE | Completion acknowledge per owning core |
| tmo_flag | output | NCORE | Timeout flag per record |
| slow_req | output | 1 | Cluster frequency reduction request |

## Verification
The assertions assume that `tmo_limit` is at least 1 and does not change while any record is live. They also assume that a core issues at most one command per cycle. The state-transition and acknowledge properties further rely on the block's own guards against FINISH from a core other than the claimer, so they do not depend on any rule about who issues commands. The directed tests change `tmo_limit` only while every record is empty, hold each command for exactly one cycle, and run the concurrent-claim and claim-versus-clear scenarios with the other records empty, so that the search target is known in advance.

// File: rtl/hop_pkg.sv
package hop_pkg;
  typedef enum logic [1:0] {ST_EMPTY = 2'd0, ST_WAIT = 2'd1, ST_RUN = 2'd2, ST_DONE = 2'd3} ent_st_e;
  typedef enum logic [1:0] {OP_POST = 2'd0, OP_CLAIM = 2'd1, OP_FINISH = 2'd2, OP_CLEAR = 2'd3} op_e;
  typedef enum logic [1:0] {RS_OK = 2'd0, RS_RETRY = 2'd1, RS_ERR = 2'd2, RS_NONE = 2'd3} rsp_e;

  // a record counts toward its timeout while it is waiting or running
  function automatic logic is_live(ent_st_e s);
    return (s == ST_WAIT) || (s == ST_RUN);
  endfunction
endpackage

// File: rtl/hop_claim_arb.sv
module hop_claim_arb #(
  parameter int NCORE = 16,
  localparam int IDX_W = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] claim_req,
  input  logic [NCORE-1:0] waiting,
  output logic [NCORE-1:0] win,
  output logic [NCORE-1:0] lose,
  output logic [IDX_W-1:0] win_idx,
  output logic             hit,
  output logic [IDX_W-1:0] tgt
);
  // lowest requesting index, found flag in the top bit
  function automatic logic [IDX_W:0] lowest(logic [NCORE-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = NCORE - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, IDX_W'(i)};
    return r;
  endfunction

  // circular walk starting after 'me', own record excluded
  function automatic logic [IDX_W:0] circ_find(logic [NCORE-1:0] w, logic [IDX_W-1:0] me);
    logic [IDX_W:0] r;
    int j;
    r = '0;
    for (int off = NCORE - 1; off >= 1; off--) begin
      j = (int'(me) + off) % NCORE;
      if (w[j]) r = {1'b1, IDX_W'(j)};
    end
    return r;
  endfunction

  logic [IDX_W:0] low_r, find_r;
  logic           any_req;

  always_comb begin
    low_r   = lowest(claim_req);
    any_req = low_r[IDX_W];
    win_idx = low_r[IDX_W-1:0];
    win     = '0;
    if (any_req) win[win_idx] = 1'b1;
    lose    = claim_req & ~win;
    find_r  = circ_find(waiting, win_idx);
    hit     = any_req && find_r[IDX_W];
    tgt     = find_r[IDX_W-1:0];
  end

  a_r5_single_winner: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(win));
  a_r4_not_self: assert property (@(posedge clk) disable iff (!rst_n) hit |-> (tgt != win_idx));
  a_r4_target_waits: assert property (@(posedge clk) disable iff (!rst_n) hit |-> waiting[tgt]);
endmodule

// File: rtl/hop_timer.sv
module hop_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             active,
  input  logic [TMR_W-1:0] limit,
  output logic             flag
);
  logic [TMR_W-1:0] cnt_q;

  function automatic logic at_end(logic [TMR_W-1:0] c, logic [TMR_W-1:0] l);
    return c == (l - TMR_W'(1));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flag  <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
      flag  <= 1'b0;
    end else if (active && !flag) begin
      cnt_q <= cnt_q + TMR_W'(1);
      if (at_end(cnt_q, limit)) flag <= 1'b1;
    end
  end

  a_r8_rise_when_live: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(active));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !restart) |=> flag);
endmodule

// File: rtl/hop_irq.sv
module hop_irq #(
  parameter int NCORE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] post_ok,
  input  logic [NCORE-1:0] claim_seen,
  input  logic [NCORE-1:0] en,
  input  logic [NCORE-1:0] idle_only,
  input  logic [NCORE-1:0] idle,
  output logic [NCORE-1:0] irq
);
  logic [NCORE-1:0] pend_q, pend_d, from_other;

  function automatic logic gate(logic p, logic e, logic io, logic id);
    return p && e && (!io || id);
  endfunction

  always_comb begin
    for (int k = 0; k < NCORE; k++) begin
      from_other[k] = |(post_ok & ~(NCORE'(1) << k));
      pend_d[k]     = (pend_q[k] && !claim_seen[k]) || from_other[k];
      irq[k]        = gate(pend_q[k], en[k], idle_only[k], idle[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  for (genvar k = 0; k < NCORE; k++) begin : g_chk
    a_r3_no_self_set: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[k]) |-> $past(|(post_ok & ~(NCORE'(1) << k))));
  end
endmodule

// File: rtl/hop_table.sv
module hop_table import hop_pkg::*; #(
  parameter int NCORE = 16,
  parameter int SP_W  = 32,
  parameter int AD_W  = 32,
  parameter int TMR_W = 16,
  localparam int IDX_W = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCORE-1:0]       cmd_valid,
  input  logic [2*NCORE-1:0]     cmd_op,
  input  logic [IDX_W*NCORE-1:0] cmd_idx,
  input  logic [SP_W*NCORE-1:0]  cmd_sp,
  input  logic [AD_W*NCORE-1:0]  cmd_addr,
  input  logic [NCORE-1:0]       irq_en,
  input  logic [NCORE-1:0]       idle_only,
  input  logic [NCORE-1:0]       core_idle,
  input  logic [TMR_W-1:0]       tmo_limit,
  output logic [NCORE-1:0]       rsp_valid,
  output logic [2*NCORE-1:0]     rsp_code,
  output logic [IDX_W*NCORE-1:0] rsp_idx,
  output logic [SP_W*NCORE-1:0]  rsp_sp,
  output logic [AD_W*NCORE-1:0]  rsp_addr,
  output logic [2*NCORE-1:0]     entry_state,
  output logic [NCORE-1:0]       req_irq,
  output logic [NCORE-1:0]       ack_irq,
  output logic [NCORE-1:0]       tmo_flag,
  output logic                   slow_req
);
  ent_st_e          st_q   [NCORE];
  logic [SP_W-1:0]  sp_q   [NCORE];
  logic [AD_W-1:0]  addr_q [NCORE];
  logic [IDX_W-1:0] srv_q  [NCORE];

  logic [NCORE-1:0] claim_req, waiting, win, lose;
  logic [NCORE-1:0] post_ok, fin_ok, clr_ok, ack_d;
  logic [IDX_W-1:0] win_idx, tgt;
  logic             hit;
  op_e              op     [NCORE];
  logic [IDX_W-1:0] eidx   [NCORE];
  rsp_e             code_d [NCORE];

  // ---------------- command decode ----------------
  always_comb begin
    for (int k = 0; k < NCORE; k++) begin
      op[k]        = op_e'(cmd_op[2*k +: 2]);
      eidx[k]      = cmd_idx[IDX_W*k +: IDX_W];
      claim_req[k] = cmd_valid[k] && (op[k] == OP_CLAIM);
      waiting[k]   = (st_q[k] == ST_WAIT);
    end
  end

  hop_claim_arb #(.NCORE(NCORE)) u_arb (
    .clk(clk), .rst_n(rst_n), .claim_req(claim_req), .waiting(waiting),
    .win(win), .lose(lose), .win_idx(win_idx), .hit(hit), .tgt(tgt)
  );

  always_comb begin
    ack_d = '0;
    for (int k = 0; k < NCORE; k++) begin
      post_ok[k] = cmd_valid[k] && (op[k] == OP_POST) && (st_q[k] == ST_EMPTY);
      fin_ok[k]  = cmd_valid[k] && (op[k] == OP_FINISH) && (st_q[eidx[k]] == ST_RUN)
                   && (srv_q[eidx[k]] == IDX_W'(k));
      // a claim landing on this record in the same cycle takes precedence
      clr_ok[k]  = cmd_valid[k] && (op[k] == OP_CLEAR) && ((st_q[k] == ST_DONE) ||
                   ((st_q[k] == ST_WAIT) && !(hit && tgt == IDX_W'(k))));
      if (fin_ok[k]) ack_d[eidx[k]] = 1'b1;
      unique case (op[k])
        OP_POST:   code_d[k] = post_ok[k] ? RS_OK : RS_ERR;
        OP_CLAIM:  code_d[k] = lose[k] ? RS_RETRY : (hit ? RS_OK : RS_NONE);
        OP_FINISH: code_d[k] = fin_ok[k] ? RS_OK : RS_ERR;
        default:   code_d[k] = clr_ok[k] ? RS_OK : RS_ERR;
      endcase
    end
  end

  // ---------------- record storage ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NCORE; e++) begin
        st_q[e]   <= ST_EMPTY;
        sp_q[e]   <= '0;
        addr_q[e] <= '0;
        srv_q[e]  <= '0;
      end
    end else begin
      for (int e = 0; e < NCORE; e++) begin
        if (post_ok[e]) begin
          st_q[e]   <= ST_WAIT;
          sp_q[e]   <= cmd_sp[SP_W*e +: SP_W];
          addr_q[e] <= cmd_addr[AD_W*e +: AD_W];
        end
        if (clr_ok[e]) st_q[e] <= ST_EMPTY;
      end
      if (hit) begin
        st_q[tgt]  <= ST_RUN;
        srv_q[tgt] <= win_idx;
      end
      for (int k = 0; k < NCORE; k++)
        if (fin_ok[k]) st_q[eidx[k]] <= ST_DONE;
    end
  end

  // ---------------- registered responses ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_code  <= '0;
      rsp_idx   <= '0;
      rsp_sp    <= '0;
      rsp_addr  <= '0;
      ack_irq   <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      ack_irq   <= ack_d;
      for (int k = 0; k < NCORE; k++) begin
        rsp_code[2*k +: 2] <= code_d[k];
        if (win[k] && hit) begin
          rsp_idx[IDX_W*k +: IDX_W] <= tgt;
          rsp_sp[SP_W*k +: SP_W]    <= sp_q[tgt];
          rsp_addr[AD_W*k +: AD_W]  <= addr_q[tgt];
        end else begin
          rsp_idx[IDX_W*k +: IDX_W] <= '0;
          rsp_sp[SP_W*k +: SP_W]    <= '0;
          rsp_addr[AD_W*k +: AD_W]  <= '0;
        end
      end
    end
  end

  // ---------------- timers and interrupts ----------------
  for (genvar e = 0; e < NCORE; e++) begin : g_ent
    hop_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .restart(post_ok[e] || clr_ok[e]),
      .active(is_live(st_q[e])), .limit(tmo_limit), .flag(tmo_flag[e])
    );
    assign entry_state[2*e +: 2] = st_q[e];

    a_r6_ack_when_done: assert property (@(posedge clk) disable iff (!rst_n)
      ack_irq[e] |-> (st_q[e] == ST_DONE));
    a_r2_from_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[e] == ST_EMPTY) |=> (st_q[e] == ST_EMPTY || st_q[e] == ST_WAIT));
    a_r7_from_done: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[e] == ST_DONE) |=> (st_q[e] == ST_DONE || st_q[e] == ST_EMPTY));
    a_r6_run_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[e] == ST_RUN) |=> (st_q[e] == ST_RUN || st_q[e] == ST_DONE));
  end

  hop_irq #(.NCORE(NCORE)) u_irq (
    .clk(clk), .rst_n(rst_n), .post_ok(post_ok), .claim_seen(claim_req),
    .en(irq_en), .idle_only(idle_only), .idle(core_idle), .irq(req_irq)
  );

  assign slow_req = |tmo_flag;

  a_r2_one_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(cmd_valid));
endmodule

// File: tb/hop_table_bench.sv
module hop_table_bench;
  localparam int N = 16, IW = 4, SW = 32, AW = 32, TW = 16;
  localparam logic [1:0] POST = 0, CLAIM = 1, FINISH = 2, CLEAR = 3;
  localparam logic [1:0] OK = 0, RETRY = 1, ERR = 2, NONE = 3;
  localparam logic [1:0] EMPTY = 0, WAITS = 1, RUNS = 2, DONES = 3;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] cmd_valid = '0, irq_en, idle_only, core_idle;
  logic [2*N-1:0] cmd_op = '0;
  logic [IW*N-1:0] cmd_idx = '0;
  logic [SW*N-1:0] cmd_sp = '0;
  logic [AW*N-1:0] cmd_addr = '0;
  logic [TW-1:0] tmo_limit = 16'd20;
  logic [N-1:0] rsp_valid, req_irq, ack_irq, tmo_flag;
  logic [2*N-1:0] rsp_code, entry_state;
  logic [IW*N-1:0] rsp_idx;
  logic [SW*N-1:0] rsp_sp;
  logic [AW*N-1:0] rsp_addr;
  logic slow_req;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hop_table u_hop_table (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .cmd_sp(cmd_sp), .cmd_addr(cmd_addr), .irq_en(irq_en), .idle_only(idle_only),
    .core_idle(core_idle), .tmo_limit(tmo_limit), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_idx(rsp_idx), .rsp_sp(rsp_sp), .rsp_addr(rsp_addr), .entry_state(entry_state),
    .req_irq(req_irq), .ack_irq(ack_irq), .tmo_flag(tmo_flag), .slow_req(slow_req)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(string req, logic [63:0] act, logic [63:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  function automatic logic [1:0] st(int e); return entry_state[2*e +: 2]; endfunction
  function automatic logic [1:0] code(int k); return rsp_code[2*k +: 2]; endfunction

  task automatic put(int k, logic [1:0] op, int idx, logic [31:0] sp, logic [31:0] ad);
    cmd_valid[k]        = 1'b1;
    cmd_op[2*k +: 2]    = op;
    cmd_idx[IW*k +: IW] = IW'(idx);
    cmd_sp[SW*k +: SW]  = sp;
    cmd_addr[AW*k +: AW] = ad;
  endtask

  task automatic step();
    @(posedge clk); #1;
    cmd_valid = '0;
  endtask

  task automatic one(int k, logic [1:0] op, int idx, logic [31:0] sp, logic [31:0] ad);
    @(negedge clk);
    put(k, op, idx, sp, ad);
    step();
  endtask

  task automatic t_reset();
    for (int e = 0; e < N; e++) chk_eq("R1 state", st(e), EMPTY);
    chk_eq("R1 irq", {req_irq, ack_irq, rsp_valid, tmo_flag}, '0);
    chk_eq("R1 slow", slow_req, 0);
  endtask

  task automatic t_post_and_irq();
    logic [N-1:0] exp;
    one(3, POST, 0, 32'h1000, 32'h2000);
    chk_eq("R2 rsp valid", rsp_valid, N'(1) << 3);
    chk_eq("R2 post ok", code(3), OK);
    chk_eq("R2 waiting", st(3), WAITS);
    exp = ~(N'(1) << 3) & ~(N'(1) << 5) & ~(N'(1) << 7);
    chk_eq("R3 req_irq gated", req_irq, exp);
    core_idle[5] = 1'b1; #1;
    chk_eq("R3 idle-only delivers when idle", req_irq, exp | (N'(1) << 5));
    one(3, POST, 0, 32'hdead, 32'hbeef);
    chk_eq("R2 repost err", code(3), ERR);
    chk_eq("R2 repost keeps state", st(3), WAITS);
  endtask

  task automatic t_claim_finish();
    one(1, CLAIM, 0, 0, 0);
    chk_eq("R4 claim ok", code(1), OK);
    chk_eq("R4 claim idx", rsp_idx[IW*1 +: IW], 3);
    chk_eq("R4 claim sp", rsp_sp[SW*1 +: SW], 32'h1000);
    chk_eq("R4 claim addr", rsp_addr[AW*1 +: AW], 32'h2000);
    chk_eq("R4 running", st(3), RUNS);
    chk_eq("R3 pending cleared by claim", req_irq[1], 0);
    one(2, CLAIM, 0, 0, 0);
    chk_eq("R4 none waiting", code(2), NONE);
    one(2, FINISH, 3, 0, 0);
    chk_eq("R6 foreign finish err", code(2), ERR);
    chk_eq("R6 no ack on err", ack_irq, '0);
    chk_eq("R6 still running", st(3), RUNS);
    one(1, FINISH, 3, 0, 0);
    chk_eq("R6 finish ok", code(1), OK);
    chk_eq("R6 done", st(3), DONES);
    chk_eq("R6 ack pulse", ack_irq, N'(1) << 3);
    @(posedge clk); #1;
    chk_eq("R6 ack one cycle", ack_irq, '0);
    one(3, CLEAR, 0, 0, 0);
    chk_eq("R7 clear done ok", code(3), OK);
    chk_eq("R7 empty", st(3), EMPTY);
    one(3, CLEAR, 0, 0, 0);
    chk_eq("R7 clear empty err", code(3), ERR);
  endtask

  task automatic t_wrap();
    @(negedge clk);
    put(14, POST, 0, 32'h14, 32'h140);
    put(2, POST, 0, 32'h2, 32'h20);
    step();
    one(15, CLAIM, 0, 0, 0);
    chk_eq("R4 wrap picks 2", rsp_idx[IW*15 +: IW], 2);
    chk_eq("R4 wrap addr", rsp_addr[AW*15 +: AW], 32'h20);
    one(0, CLAIM, 0, 0, 0);
    chk_eq("R4 next picks 14", rsp_idx[IW*0 +: IW], 14);
    one(14, CLEAR, 0, 0, 0);
    chk_eq("R7 clear running err", code(14), ERR);
    @(negedge clk);
    put(15, FINISH, 2, 0, 0);
    put(0, FINISH, 14, 0, 0);
    step();
    chk_eq("R6 two acks", ack_irq, (N'(1) << 2) | (N'(1) << 14));
    @(negedge clk);
    put(2, CLEAR, 0, 0, 0);
    put(14, CLEAR, 0, 0, 0);
    step();
  endtask

  task automatic t_contend();
    @(negedge clk);
    put(8, POST, 0, 32'h8, 32'h80);
    put(9, POST, 0, 32'h9, 32'h90);
    step();
    @(negedge clk);
    put(6, CLAIM, 0, 0, 0);
    put(4, CLAIM, 0, 0, 0);
    step();
    chk_eq("R5 low index wins", code(4), OK);
    chk_eq("R5 winner idx", rsp_idx[IW*4 +: IW], 8);
    chk_eq("R5 loser retry", code(6), RETRY);
    chk_eq("R5 other untouched", st(9), WAITS);
    one(9, CLEAR, 0, 0, 0);
    chk_eq("R7 withdraw waiting", st(9), EMPTY);
    one(4, FINISH, 8, 0, 0);
    one(8, CLEAR, 0, 0, 0);
    one(10, POST, 0, 32'hA, 32'hA0);
    @(negedge clk);
    put(10, CLEAR, 0, 0, 0);
    put(11, CLAIM, 0, 0, 0);
    step();
    chk_eq("R7 claim beats clear", code(10), ERR);
    chk_eq("R7 claim served", rsp_idx[IW*11 +: IW], 10);
    chk_eq("R7 record running", st(10), RUNS);
    one(11, FINISH, 10, 0, 0);
    one(10, CLEAR, 0, 0, 0);
  endtask

  task automatic t_timeout();
    one(13, POST, 0, 32'hD, 32'hD0);
    repeat (19) @(posedge clk);
    #1;
    chk_eq("R8 no flag before limit", tmo_flag, '0);
    @(posedge clk); #1;
    chk_eq("R8 flag at limit", tmo_flag, N'(1) << 13);
    chk_eq("R8 slow request", slow_req, 1);
    one(13, CLEAR, 0, 0, 0);
    chk_eq("R8 cleared", {tmo_flag, slow_req}, '0);
    one(13, POST, 0, 32'hD, 32'hD0);
    one(12, CLAIM, 0, 0, 0);
    one(12, FINISH, 13, 0, 0);
    repeat (40) @(posedge clk);
    #1;
    chk_eq("R8 done before limit no flag", {tmo_flag, slow_req}, '0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    irq_en = ~(N'(1) << 7);
    idle_only = N'(1) << 5;
    core_idle = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_post_and_irq();
    t_claim_finish();
    t_wrap();
    t_contend();
    t_timeout();
    summary();
  end

  initial begin
    #(8 * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule